// File: doc/BRIEF.md
# Half-Screen Line Relay Buffer

This block sits in a 720p video output path. It holds one video line of pixels in a dual-port line RAM. Pixels are written at pixel rate through a write strobe. The output side paints the left half of every active line black. For the right half it streams the stored pixels from entry 0 upward.

Reading begins in the middle of the line while the write side is still filling later entries. As a result, the right half of the screen shows the pixels of the line being written, and no frame buffer is needed. The write side must stay ahead of the read side. If a right-half pixel is fetched from an entry that no earlier cycle of the line has written, a sticky underrun flag is raised.

The RAM read takes one cycle, so the timing signals are delayed by one register to stay aligned with the pixel data. A rising edge of horizontal sync restarts both RAM positions at entry 0.

Top module: `half_line_relay`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are zero: `pix_out`, `de_out`, `hs_out`, `vs_out` and `underrun`.
- R2: `de_out`, `hs_out` and `vs_out` equal `de_in`, `hs_in` and `vs_in` of the previous clock cycle.
- R3: For active columns 0 to HALF-1, the output pixel one cycle later is black (all 24 bits zero). A column is the number of consecutive earlier cycles with `de_in` high in the current run; HALF is LINE_W/2.
- R4: For active column HALF+k, with k from 0 to HALF-1, the output pixel one cycle later is the k-th pixel (counted from 0) accepted on `wr_valid` since the last rising edge of `hs_in`.
- R5: When `de_in` is low, the output pixel one cycle later is black.
- R6: A rising edge of `hs_in` restarts writing and reading at entry 0. A pixel accepted in that cycle or later is stored as pixel 0 of the new line, and data from the previous line is never shown.
- R7: Once HALF pixels have been accepted in a line, further `wr_valid` strobes before the next rising edge of `hs_in` are ignored, and the stored pixels shown in the right half are unchanged.
- R8: `underrun` rises one cycle after a right-half column k is shown while fewer than k+1 pixels were accepted in earlier cycles of the line. A write in the same cycle does not count. The flag then stays high until reset.
- R9: If pixel k is always accepted before the cycle that shows column HALF+k, `underrun` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe for `wr_pixel` |
| wr_pixel | input | 24 | Incoming RGB pixel, 8 bits per colour |
| de_in | input | 1 | Active-video marker |
| hs_in | input | 1 | Horizontal sync, active high |
| vs_in | input | 1 | Vertical sync |
| pix_out | output | 24 | Output RGB pixel, aligned with the delayed timing |
| de_out | output | 1 | Active video delayed one cycle |
| hs_out | output | 1 | Horizontal sync delayed one cycle |
| vs_out | output | 1 | Vertical sync delayed one cycle |
| underrun | output | 1 | Sticky flag: a right-half pixel was read before it was written |

## Verification
The bench builds the block with LINE_W = 16, so HALF = 8 and each line has 22 cycles in total. With lines this short, the bench can sweep the write start cycle over every offset, from well ahead of the read side to exactly level with it, where starvation occurs. It can also overrun the RAM capacity within one line and follow a starved line with a healthy one to confirm the flag holds. Every output pixel of every cycle is compared against a bench-side line model.

// File: rtl/hlr_pkg.sv
// Package: shared pixel type and the black constant for the line relay.
// Assumes 8-bit red, green and blue packed into one 24-bit word.
package hlr_pkg;
    localparam int PIX_W = 24;
    typedef logic [PIX_W-1:0] pix_t;
    localparam pix_t BLACK = '0;
endpackage

// File: rtl/hlr_line_ram.sv
// Line RAM: one write port and one read port on a single clock.
// Reads are registered, so data appears one cycle after rd_en.
// A read and a write to the same entry in one cycle return the old
// content. The stored data has no reset.
module hlr_line_ram
    import hlr_pkg::*;
#(
    parameter int DEPTH = 640,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  pix_t          wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output pix_t          rd_data
);
    pix_t mem [DEPTH];

    // Store one pixel per accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Fetch the requested entry into the output register.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/hlr_addr_ctrl.sv
// Position control: tracks the active column and the write and read
// positions inside the line RAM, and raises the sticky underrun flag.
// Assumes a rising edge of hs_in comes before each active run, so
// that the read position matches column minus HALF.
module hlr_addr_ctrl #(
    parameter int LINE_W = 1280,
    parameter int HALF   = 640,
    parameter int NW     = 10,
    parameter int CW     = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          de_in,
    input  logic          hs_in,
    output logic          ram_we,
    output logic [NW-1:0] ram_wa,
    output logic          ram_re,
    output logic [NW-1:0] ram_ra,
    output logic          show,
    output logic          underrun
);
    logic          hs_prev;
    logic [CW-1:0] col;
    logic [NW-1:0] wr_cnt, rd_cnt;
    logic [NW-1:0] wr_idx, rd_idx;
    logic          hs_rise, do_wr, starve, und_q;

    // Derive this cycle's positions, restarting on the sync edge.
    always_comb begin
        hs_rise = hs_in & ~hs_prev;
        wr_idx  = hs_rise ? '0 : wr_cnt;
        rd_idx  = hs_rise ? '0 : rd_cnt;
        do_wr   = wr_valid && (wr_idx < NW'(HALF));
        show    = de_in && (col >= CW'(HALF)) && (rd_idx < NW'(HALF));
        starve  = show && (rd_idx >= wr_idx);
        ram_we  = do_wr;
        ram_wa  = wr_idx;
        ram_re  = show;
        ram_ra  = rd_idx;
    end

    // Advance the column, write and read positions and the underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_prev <= 1'b0;
            col     <= '0;
            wr_cnt  <= '0;
            rd_cnt  <= '0;
            und_q   <= 1'b0;
        end else begin
            hs_prev <= hs_in;
            col     <= de_in ? ((col == CW'(LINE_W)) ? col : col + CW'(1)) : '0;
            wr_cnt  <= do_wr ? wr_idx + NW'(1) : wr_idx;
            rd_cnt  <= show ? rd_idx + NW'(1) : rd_idx;
            und_q   <= und_q | starve;
        end
    end

    assign underrun = und_q;

    assert_sticky_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        und_q |=> und_q);

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= NW'(HALF));

    assert_line_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(hs_in)) |=> (wr_cnt <= NW'(1) && rd_cnt == '0));
endmodule

// File: rtl/hlr_out_align.sv
// Output alignment: delays the timing signals by the one-cycle RAM
// read latency and selects between RAM data and black. Assumes that
// show is only high while de_in is high.
module hlr_out_align
    import hlr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic de_in,
    input  logic hs_in,
    input  logic vs_in,
    input  logic show,
    input  pix_t rd_data,
    output pix_t pix_out,
    output logic de_out,
    output logic hs_out,
    output logic vs_out
);
    logic de_q, hs_q, vs_q, show_q;

    // Delay the timing and the pixel-select by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q   <= 1'b0;
            hs_q   <= 1'b0;
            vs_q   <= 1'b0;
            show_q <= 1'b0;
        end else begin
            de_q   <= de_in;
            hs_q   <= hs_in;
            vs_q   <= vs_in;
            show_q <= show;
        end
    end

    // Pick the stored pixel for the right half, black elsewhere.
    always_comb pix_out = show_q ? rd_data : BLACK;

    assign de_out = de_q;
    assign hs_out = hs_q;
    assign vs_out = vs_q;

    assert_timing_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (de_out == $past(de_in) && hs_out == $past(hs_in)
                          && vs_out == $past(vs_in)));
endmodule

// File: rtl/half_line_relay.sv
// Top: half-screen line relay. The left half of each active line is
// black, and the right half streams pixels of the line being written.
// Assumes at most LINE_W active cycles per line and one hs_in
// rising edge per line, before its active run.
module half_line_relay
    import hlr_pkg::*;
#(
    parameter int LINE_W = 1280
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [PIX_W-1:0] wr_pixel,
    input  logic             de_in,
    input  logic             hs_in,
    input  logic             vs_in,
    output logic [PIX_W-1:0] pix_out,
    output logic             de_out,
    output logic             hs_out,
    output logic             vs_out,
    output logic             underrun
);
    localparam int HALF = LINE_W / 2;
    localparam int NW   = $clog2(HALF + 1);
    localparam int CW   = $clog2(LINE_W + 1);

    logic          ram_we, ram_re, show;
    logic [NW-1:0] ram_wa, ram_ra;
    pix_t          rd_data;

    hlr_addr_ctrl #(.LINE_W(LINE_W), .HALF(HALF), .NW(NW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .de_in(de_in),
        .hs_in(hs_in), .ram_we(ram_we), .ram_wa(ram_wa), .ram_re(ram_re),
        .ram_ra(ram_ra), .show(show), .underrun(underrun)
    );

    hlr_line_ram #(.DEPTH(HALF), .AW(NW)) u_ram (
        .clk(clk), .wr_en(ram_we), .wr_addr(ram_wa), .wr_data(wr_pixel),
        .rd_en(ram_re), .rd_addr(ram_ra), .rd_data(rd_data)
    );

    hlr_out_align u_out (
        .clk(clk), .rst_n(rst_n), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
        .show(show), .rd_data(rd_data), .pix_out(pix_out), .de_out(de_out),
        .hs_out(hs_out), .vs_out(vs_out)
    );

    assert_blank_black_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!de_out) |-> (pix_out == BLACK));
endmodule

// File: tb/sim_half_line_relay.sv
module sim_half_line_relay;
    localparam int LINE_W = 16;
    localparam int HALF   = LINE_W / 2;
    localparam int SLOTS  = 2 + 2 + LINE_W + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, wr_valid = 1'b0, de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic [23:0] wr_pixel = '0;
    logic [23:0] pix_out;
    logic        de_out, hs_out, vs_out, underrun;

    half_line_relay #(.LINE_W(LINE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_pixel(wr_pixel),
        .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in), .pix_out(pix_out),
        .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out), .underrun(underrun)
    );

    always #4 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0, have_exp = 0;
    logic [23:0] mem_m [HALF];
    int col_m = 0, wcnt_m = 0;
    bit hsp_m = 0, und_m = 0;
    logic [23:0] e_pix = '0;
    bit e_dc = 0, e_de = 0, e_hs = 0, e_vs = 0, e_und = 0;
    string e_req = "R1", scen = "";

    task automatic check_outputs();
        if (!e_dc) begin
            tests++;
            if (pix_out !== e_pix) begin
                fails++;
                $display("FAIL %s%s pixel got %h exp %h", e_req, scen, pix_out, e_pix);
            end
        end
        tests++;
        if ({de_out, hs_out, vs_out} !== {e_de, e_hs, e_vs}) begin
            fails++;
            $display("FAIL %s timing got %b exp %b", (e_req == "R1") ? "R1" : "R2",
                     {de_out, hs_out, vs_out}, {e_de, e_hs, e_vs});
        end
        tests++;
        if (underrun !== e_und) begin
            fails++;
            $display("FAIL %s underrun got %b exp %b", (e_req == "R1") ? "R1" : "R8/R9",
                     underrun, e_und);
        end
    endtask

    task automatic step(input bit r, input bit de, input bit hs, input bit vs,
                        input bit we, input logic [23:0] d);
        bit rise, rd;
        int widx, ridx;
        @(negedge clk);
        if (have_exp) check_outputs();
        rst_n = r; de_in = de; hs_in = hs; vs_in = vs; wr_valid = we; wr_pixel = d;
        if (!r) begin
            col_m = 0; wcnt_m = 0; hsp_m = 0; und_m = 0;
            e_pix = '0; e_dc = 0; e_de = 0; e_hs = 0; e_vs = 0; e_und = 0; e_req = "R1";
        end else begin
            rise = hs && !hsp_m;
            widx = rise ? 0 : wcnt_m;
            ridx = col_m - HALF;
            rd   = de && col_m >= HALF && ridx < HALF;
            e_de = de; e_hs = hs; e_vs = vs;
            if (rd) begin
                e_req = "R4";
                if (ridx < widx) begin e_pix = mem_m[ridx]; e_dc = 0; end
                else begin e_dc = 1; und_m = 1; end
            end else begin
                e_pix = '0; e_dc = 0;
                e_req = de ? "R3" : "R5";
            end
            e_und = und_m;
            if (we && widx < HALF) begin mem_m[widx] = d; wcnt_m = widx + 1; end
            else wcnt_m = widx;
            col_m = de ? ((col_m < LINE_W) ? col_m + 1 : col_m) : 0;
            hsp_m = hs;
        end
        have_exp = 1;
    endtask

    // One line: sync 2 cycles, back porch 2, active LINE_W, front porch 2.
    task automatic line(input int tag, input int wfirst, input int wgap,
                        input int wtotal, input bit vs);
        int n = 0;
        for (int s = 0; s < SLOTS; s++) begin
            bit de = (s >= 4 && s < 4 + LINE_W);
            bit hs = (s < 2);
            bit we = (s >= wfirst && n < wtotal && ((s - wfirst) % wgap) == 0);
            logic [7:0] t8 = 8'(tag);
            logic [7:0] n8 = 8'(n);
            step(1, de, hs, vs, we, {t8, n8, t8 ^ n8});
            if (we) n++;
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 24'hFFFFFF); // R1 during reset
        step(0, 0, 0, 0, 0, '0);
        scen = "";
        line(1, 0, 1, 8, 1);
        line(2, 4, 1, 8, 0);
        scen = " R7";
        line(3, 2, 1, 20, 0);
        scen = " R6";
        line(4, 0, 1, 8, 1);
        scen = " R7";
        line(5, 0, 1, 22, 0);
        scen = " R4";
        line(6, 4, 2, 8, 0);
        for (int d = 0; d <= HALF; d++) begin
            step(0, 0, 0, 0, 0, '0);
            step(0, 0, 0, 0, 0, '0);
            scen = " R9";
            line(10 + d, 4 + d, 1, 8, d[0]);
            scen = " R8";
            line(40 + d, 0, 1, 8, 0);
        end
        step(1, 0, 0, 0, 0, '0);
        step(1, 0, 0, 0, 0, '0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule